// File: doc/BRIEF.md
# Balanced Ternary Trit Adder

This block adds balanced ternary digits (trits), each taking the value -1, 0 or +1 and each carried on a 2-bit binary code. In its full-adder form it takes two operand trits and a carry trit and returns one sum trit and one signed carry trit. In its half-adder form the carry input plays no part. The block is purely combinational. It is meant as the digit cell of wider balanced ternary datapaths, such as summing trees for short-word-length signal processing, where a parent block chains or trees several instances.

Two implementations sit behind one parameter. The default builds the adder from fourteen trit-controlled three-way select cells. The alternative reads a constant table indexed by the three input codes, and the table is computed when the design is elaborated. Any input that carries the unused code raises an error flag, and both outputs then fall to the zero code. The half-adder form does not look at the carry input at all.

Top module: `tern_adder`

## Requirements
- R1: Trit codes are 2'b11 = -1, 2'b00 = 0, 2'b01 = +1. The sum and carry outputs only ever carry one of these three codes.
- R2: With legal inputs in the full-adder form (FULL_ADD=1), a + b + cin = 3*cout + sum, with sum and cout each in {-1,0,+1}.
- R3: Corner cases of the full adder: +1,+1,+1 gives cout +1 and sum 0; +1,+1,0 gives cout +1 and sum -1; -1,-1,-1 gives cout -1 and sum 0; -1,-1,0 gives cout -1 and sum +1.
- R4: In the half-adder form (FULL_ADD=0) with legal a and b, a + b = 3*cout + sum for every cin code.
- R5: If any input the active form uses carries the code 2'b10, err is 1 and both sum and cout are 2'b00.
- R6: err is 0 whenever every input the active form uses is legal.
- R7: The select-cell form (USE_LUT=0) and the table form (USE_LUT=1) give identical sum, cout and err for all 64 input code combinations.
- R8: In the half-adder form, the code 2'b10 on cin does not raise err and does not change sum or cout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_code | input | 2 | First operand trit |
| b_code | input | 2 | Second operand trit |
| cin_code | input | 2 | Carry-in trit; ignored when FULL_ADD=0 |
| sum_code | output | 2 | Sum trit |
| cout_code | output | 2 | Carry-out trit |
| err | output | 1 | High when a used input carries the illegal code |

## Verification
The hardest situations to reach are the double-carry cases, where both partial carries inside the select network are non-zero and cancel, or where the sum wraps twice. They arise only for a few operand triples such as +1,+1,-1 and -1,-1,+1. The bench therefore sweeps all 64 code triples, the illegal code included, through one instance of each form side by side. Every result is compared with an integer model, and the two implementations are also compared with each other. A half-adder instance gets the same sweep, so an illegal carry-in is shown not to disturb it.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T_NEG  = 2'b11;
  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_POS  = 2'b01;
  localparam trit_t T_BAD  = 2'b10;

  function automatic logic trit_legal(input trit_t t);
    return t != T_BAD;
  endfunction

  function automatic int trit_val(input trit_t t);
    case (t)
      T_NEG:   return -1;
      T_POS:   return 1;
      default: return 0;
    endcase
  endfunction

  function automatic trit_t trit_enc(input int v);
    if (v < 0) return T_NEG;
    if (v > 0) return T_POS;
    return T_ZERO;
  endfunction
endpackage

// File: rtl/tern_sel3.sv
module tern_sel3
  import tern_pkg::*;
(
  input  trit_t ctrl,
  input  trit_t d_neg,
  input  trit_t d_zero,
  input  trit_t d_pos,
  output trit_t y
);
  always_comb begin
    case (ctrl)
      T_NEG:   y = d_neg;
      T_ZERO:  y = d_zero;
      T_POS:   y = d_pos;
      default: y = T_ZERO;
    endcase
  end
endmodule

// File: rtl/tern_sel_fa.sv
module tern_sel_fa
  import tern_pkg::*;
(
  input  trit_t a,
  input  trit_t b,
  input  trit_t c,
  output trit_t sum,
  output trit_t cout
);
  trit_t a_up, a_dn, s1, s1_up, s1_dn;
  trit_t a_lo, a_hi, c1, c1_up, c1_dn, adj_n, adj_p;

  // modulo-3 sum of a and b, then of that and c
  tern_sel3 u_a_up  (.ctrl(a),  .d_neg(T_ZERO), .d_zero(T_POS), .d_pos(T_NEG),  .y(a_up));
  tern_sel3 u_a_dn  (.ctrl(a),  .d_neg(T_POS),  .d_zero(T_NEG), .d_pos(T_ZERO), .y(a_dn));
  tern_sel3 u_s1    (.ctrl(b),  .d_neg(a_dn),   .d_zero(a),     .d_pos(a_up),   .y(s1));
  tern_sel3 u_s1_up (.ctrl(s1), .d_neg(T_ZERO), .d_zero(T_POS), .d_pos(T_NEG),  .y(s1_up));
  tern_sel3 u_s1_dn (.ctrl(s1), .d_neg(T_POS),  .d_zero(T_NEG), .d_pos(T_ZERO), .y(s1_dn));
  tern_sel3 u_sum   (.ctrl(c),  .d_neg(s1_dn),  .d_zero(s1),    .d_pos(s1_up),  .y(sum));

  // carry of a+b
  tern_sel3 u_a_lo  (.ctrl(a),  .d_neg(T_NEG),  .d_zero(T_ZERO), .d_pos(T_ZERO), .y(a_lo));
  tern_sel3 u_a_hi  (.ctrl(a),  .d_neg(T_ZERO), .d_zero(T_ZERO), .d_pos(T_POS),  .y(a_hi));
  tern_sel3 u_c1    (.ctrl(b),  .d_neg(a_lo),   .d_zero(T_ZERO), .d_pos(a_hi),   .y(c1));

  // final carry: c1 shifted by one when s1 and c overflow together
  tern_sel3 u_c1_up (.ctrl(c1), .d_neg(T_ZERO), .d_zero(T_POS), .d_pos(T_NEG),  .y(c1_up));
  tern_sel3 u_c1_dn (.ctrl(c1), .d_neg(T_POS),  .d_zero(T_NEG), .d_pos(T_ZERO), .y(c1_dn));
  tern_sel3 u_adj_n (.ctrl(s1), .d_neg(c1_dn),  .d_zero(c1),    .d_pos(c1),     .y(adj_n));
  tern_sel3 u_adj_p (.ctrl(s1), .d_neg(c1),     .d_zero(c1),    .d_pos(c1_up),  .y(adj_p));
  tern_sel3 u_cout  (.ctrl(c),  .d_neg(adj_n),  .d_zero(c1),    .d_pos(adj_p),  .y(cout));
endmodule

// File: rtl/tern_lut_fa.sv
module tern_lut_fa
  import tern_pkg::*;
(
  input  trit_t a,
  input  trit_t b,
  input  trit_t c,
  output trit_t sum,
  output trit_t cout
);
  localparam int N_ENTRY = 64;

  function automatic logic [N_ENTRY-1:0][3:0] build_table();
    logic [N_ENTRY-1:0][3:0] tbl;
    for (int i = 0; i < N_ENTRY; i++) begin
      trit_t ta, tb, tc;
      int tot, cy;
      ta = trit_t'(i >> 4);
      tb = trit_t'(i >> 2);
      tc = trit_t'(i);
      tot = trit_val(ta) + trit_val(tb) + trit_val(tc);
      cy = (tot > 1) ? 1 : ((tot < -1) ? -1 : 0);
      tbl[i] = {trit_enc(cy), trit_enc(tot - 3 * cy)};
    end
    return tbl;
  endfunction

  localparam logic [N_ENTRY-1:0][3:0] TABLE = build_table();

  logic [3:0] entry;
  assign entry = TABLE[{a, b, c}];
  assign cout  = entry[3:2];
  assign sum   = entry[1:0];
endmodule

// File: rtl/tern_adder.sv
module tern_adder
  import tern_pkg::*;
#(
  parameter bit FULL_ADD = 1'b1,
  parameter bit USE_LUT  = 1'b0
) (
  input  logic [1:0] a_code,
  input  logic [1:0] b_code,
  input  logic [1:0] cin_code,
  output logic [1:0] sum_code,
  output logic [1:0] cout_code,
  output logic       err
);
  trit_t c_eff, raw_sum, raw_cout;
  logic  c_bad;

  generate
    if (FULL_ADD) begin : g_full
      assign c_eff = cin_code;
      assign c_bad = !trit_legal(cin_code);
    end else begin : g_half
      assign c_eff = T_ZERO;
      assign c_bad = 1'b0;
    end

    if (USE_LUT) begin : g_lut
      tern_lut_fa u_core (.a(a_code), .b(b_code), .c(c_eff), .sum(raw_sum), .cout(raw_cout));
    end else begin : g_sel
      tern_sel_fa u_core (.a(a_code), .b(b_code), .c(c_eff), .sum(raw_sum), .cout(raw_cout));
    end
  endgenerate

  assign err       = !trit_legal(a_code) || !trit_legal(b_code) || c_bad;
  assign sum_code  = err ? T_ZERO : raw_sum;
  assign cout_code = err ? T_ZERO : raw_cout;

  always_comb begin
    if (!$isunknown({a_code, b_code, cin_code})) begin
      AST_OUT_LEGAL: assert (trit_legal(sum_code) && trit_legal(cout_code)); // R1
      AST_ERR_ZEROES: assert (!err || (sum_code == T_ZERO && cout_code == T_ZERO)); // R5
      if (FULL_ADD && !err)
        AST_FULL_BALANCE: assert (trit_val(a_code) + trit_val(b_code) + trit_val(cin_code)
                                  == 3 * trit_val(cout_code) + trit_val(sum_code)); // R2
      if (!FULL_ADD && !err)
        AST_HALF_BALANCE: assert (trit_val(a_code) + trit_val(b_code)
                                  == 3 * trit_val(cout_code) + trit_val(sum_code)); // R4
      if (!FULL_ADD)
        AST_HALF_CIN_IGNORED: assert (err == (!trit_legal(a_code) || !trit_legal(b_code))); // R8
    end
  end
endmodule

// File: tb/tern_adder_tb.sv
module tern_adder_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] a, b, c;
  logic [1:0] s_sel, co_sel, s_lut, co_lut, s_half, co_half;
  logic       e_sel, e_lut, e_half;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  tern_adder #(.FULL_ADD(1'b1), .USE_LUT(1'b0)) dut_i
    (.a_code(a), .b_code(b), .cin_code(c), .sum_code(s_sel), .cout_code(co_sel), .err(e_sel));
  tern_adder #(.FULL_ADD(1'b1), .USE_LUT(1'b1)) dut_lut
    (.a_code(a), .b_code(b), .cin_code(c), .sum_code(s_lut), .cout_code(co_lut), .err(e_lut));
  tern_adder #(.FULL_ADD(1'b0), .USE_LUT(1'b0)) dut_half
    (.a_code(a), .b_code(b), .cin_code(c), .sum_code(s_half), .cout_code(co_half), .err(e_half));

  function automatic int dec(input logic [1:0] t);
    return (t == 2'b11) ? -1 : ((t == 2'b01) ? 1 : 0);
  endfunction
  function automatic logic [1:0] enc(input int v);
    return (v < 0) ? 2'b11 : ((v > 0) ? 2'b01 : 2'b00);
  endfunction

  task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%b b=%b c=%b actual={err,cout,sum}=%b expected=%b", req, a, b, c, act, exp);
    end
  endtask

  task automatic expect_out(input int tot, input bit bad, output logic [4:0] e);
    int cy;
    cy = (tot > 1) ? 1 : ((tot < -1) ? -1 : 0);
    e = bad ? 5'b1_00_00 : {1'b0, enc(cy), enc(tot - 3 * cy)};
  endtask

  initial begin
    logic [4:0] ef, eh, af, al, ah;
    a = 2'b00; b = 2'b00; c = 2'b00;
    @(negedge clk); #1;
    af = {e_sel, co_sel, s_sel};
    check(af == 5'b0, "R6 all-zero start", af, 5'b0);

    for (int i = 0; i < 64; i++) begin
      bit bad_f, bad_h;
      int tf, th;
      @(negedge clk);
      a = 2'(i >> 4); b = 2'(i >> 2); c = 2'(i);
      #1;
      bad_h = (a == 2'b10) || (b == 2'b10);
      bad_f = bad_h || (c == 2'b10);
      tf = dec(a) + dec(b) + dec(c);
      th = dec(a) + dec(b);
      expect_out(tf, bad_f, ef);
      expect_out(th, bad_h, eh);
      af = {e_sel, co_sel, s_sel};
      al = {e_lut, co_lut, s_lut};
      ah = {e_half, co_half, s_half};

      check(co_sel != 2'b10 && s_sel != 2'b10 && co_half != 2'b10 && s_half != 2'b10,
            "R1 legal output codes", af, ef);
      if (bad_f) check(af == ef, "R5 illegal input zeroes outputs", af, ef);
      else begin
        check(af == ef, "R2 full sum and carry", af, ef);
        check(e_sel == 1'b0, "R6 no error on legal inputs", af, ef);
      end
      if (a == b && (c == a || c == 2'b00) && a != 2'b00 && !bad_f)
        check(af == ef, "R3 saturated corner", af, ef);
      check(al == af, "R7 table matches select network", al, af);
      check(al == ef, "R7 table matches model", al, ef);
      if (bad_h) check(ah == eh, "R5 half illegal operand", ah, eh);
      else if (c == 2'b10) check(ah == eh, "R8 half ignores illegal cin", ah, eh);
      else check(ah == eh, "R4 half sum and carry", ah, eh);
    end

    a = 2'b01; b = 2'b01; c = 2'b01; #1;
    af = {e_sel, co_sel, s_sel};
    check(af == 5'b0_01_00, "R3 +1+1+1", af, 5'b0_01_00);
    a = 2'b11; b = 2'b11; c = 2'b11; #1;
    af = {e_sel, co_sel, s_sel};
    check(af == 5'b0_11_00, "R3 -1-1-1", af, 5'b0_11_00);
    a = 2'b01; b = 2'b01; c = 2'b00; #1;
    af = {e_sel, co_sel, s_sel};
    check(af == 5'b0_01_11, "R3 +1+1+0", af, 5'b0_01_11);
    a = 2'b00; b = 2'b11; c = 2'b11; #1;
    af = {e_sel, co_sel, s_sel};
    check(af == 5'b0_11_01, "R3 0-1-1", af, 5'b0_11_01);
    done = 1;
  end

  initial begin
    for (int k = 0; k < 5000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule